// File: doc/BRIEF.md
# Mostly-Sequential Read Address Generator

This block produces the stream of read addresses for a large read-only memory. The memory is addressed in 8-byte quadwords across a full 32-bit (4 GiB) space. Each time the executing program requests a read, it supplies a 32-bit address value. The block issues its current read address and then, for the next read, normally steps forward by one quadword. The supplied value is folded into a 32-bit mixing register by XOR. When the mixing register's low 13 bits come out all zero after a read, the next read goes to the mixing register's value instead of the next quadword, and a one-cycle flag marks that jump so that a prefetch unit can be told ahead of time.

A seed load starts a fresh stream. The host supplies the 32-bit slice of its seed that selects the starting address (seed bits 95:64). The block forces that value onto an 8-byte boundary and clears the mixing register. The memory itself, data return and the prefetch buffer are outside this block.

Top module: `seq_read_addr_gen`

## Requirements
- R1: While rstN is low, and on the first edge after it goes high, memAddr is 0 and jumpPulse is 0.
- R2: A cycle with seedLoad high sets memAddr after that edge to seedAddr with bits 2:0 forced to 0. It clears the mixing register to zero and leaves jumpPulse low.
- R3: When seedLoad and rdReq are both high in the same cycle, the seed load wins. The read is dropped and rdAddrIn is not mixed in.
- R4: Bits 2:0 of memAddr are 0 in every cycle.
- R5: A read (rdReq high, seedLoad low) that does not trigger a jump makes memAddr, after that edge, the previous memAddr plus 8.
- R6: The sequential step wraps modulo 2^32, so 0xFFFFFFF8 is followed by 0x00000000.
- R7: On every accepted read, the mixing register becomes itself XOR rdAddrIn. If bits 12:0 of the new value are all 0, memAddr after that edge takes the new mixing value, with bits 2:0 cleared, in place of the plus-8 step.
- R8: jumpPulse is high for exactly the one cycle following an edge on which R7 redirected memAddr, and it is low otherwise.
- R9: In a cycle with neither rdReq nor seedLoad high, memAddr and the mixing register keep their values, and jumpPulse is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| seedLoad | input | 1 | Starts a new address stream from seedAddr |
| seedAddr | input | 32 | Seed bits 95:64, used as the starting address |
| rdReq | input | 1 | One read request; at most one per clock |
| rdAddrIn | input | 32 | Program-supplied address value folded into the mixing register |
| memAddr | output | 32 | Quadword address for the current read |
| jumpPulse | output | 1 | Marks that memAddr was just loaded from the mixing register |

## Verification
The bench goes after the trigger boundary. It sweeps the mixing values whose low 13 bits are exactly zero and those that miss by one bit. A design that tested too few or too many low bits would jump on the wrong reads or step past the right ones. It also covers a seed load and a read in the same cycle, and stepping past the top of the address space. A design that mixed in the dropped read would take a later jump differently, and one that saturated or kept carry bits would not return to zero at the wrap. A seed load that did not clear the mixing register is caught by the first read after it, which would otherwise jump.

// File: rtl/seq_rd_pkg.sv
package seq_rd_pkg;
  // Strobes from control to datapath, one cycle's decisions
  typedef struct packed {
    logic loadSeed;  // restart stream from seed value
    logic takeRead;  // accept one read and mix its address
    logic takeJump;  // redirect next address to mixing value
  } rdStrobe_t;
endpackage

// File: rtl/seq_rd_datapath.sv
module seq_rd_datapath
  import seq_rd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3,
  parameter int TRIG_BITS  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [ADDR_W-1:0] seedAddr,
  input  logic [ADDR_W-1:0] rdAddrIn,
  output logic              trigHit,
  output logic [ADDR_W-1:0] memAddr
);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(1) << ALIGN_BITS;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(STEP - ADDR_W'(1));

  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] mixReg;
  logic [ADDR_W-1:0] mixNext;

  always_comb begin
    mixNext = mixReg ^ rdAddrIn;
    trigHit = (mixNext[TRIG_BITS-1:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      mixReg  <= '0;
    end else if (strobe.loadSeed) begin
      addrReg <= seedAddr & ALIGN_MASK;
      mixReg  <= '0;
    end else if (strobe.takeRead) begin
      mixReg <= mixNext;
      if (strobe.takeJump) addrReg <= mixNext & ALIGN_MASK;
      else                 addrReg <= addrReg + STEP;
    end
  end

  assign memAddr = addrReg;
endmodule

// File: rtl/seq_rd_ctrl.sv
module seq_rd_ctrl
  import seq_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      seedLoad,
  input  logic      rdReq,
  input  logic      trigHit,
  output rdStrobe_t strobe,
  output logic      jumpPulse
);
  always_comb begin
    strobe.loadSeed = seedLoad;
    strobe.takeRead = rdReq & ~seedLoad;
    strobe.takeJump = rdReq & ~seedLoad & trigHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) jumpPulse <= 1'b0;
    else       jumpPulse <= strobe.takeJump;
  end
endmodule

// File: rtl/seq_read_addr_gen.sv
module seq_read_addr_gen
  import seq_rd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3,
  parameter int TRIG_BITS  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seedLoad,
  input  logic [ADDR_W-1:0] seedAddr,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddrIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              jumpPulse
);
  rdStrobe_t strobe;
  logic      trigHit;

  seq_rd_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .seedLoad (seedLoad),
    .rdReq    (rdReq),
    .trigHit  (trigHit),
    .strobe   (strobe),
    .jumpPulse(jumpPulse)
  );

  seq_rd_datapath #(
    .ADDR_W    (ADDR_W),
    .ALIGN_BITS(ALIGN_BITS),
    .TRIG_BITS (TRIG_BITS)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .seedAddr(seedAddr),
    .rdAddrIn(rdAddrIn),
    .trigHit (trigHit),
    .memAddr (memAddr)
  );
endmodule

// File: rtl/seq_rd_checker.sv
module seq_rd_checker #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              seedLoad,
  input logic [ADDR_W-1:0] seedAddr,
  input logic              rdReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              jumpPulse
);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(1) << ALIGN_BITS;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(STEP - ADDR_W'(1));

  // R4
  aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memAddr[ALIGN_BITS-1:0] == '0);

  // R2
  seed_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> (memAddr == ($past(seedAddr) & ALIGN_MASK)) && !jumpPulse);

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !seedLoad) |=> jumpPulse || (memAddr == $past(memAddr) + STEP));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdReq && !seedLoad) |=> $stable(memAddr) && !jumpPulse);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    jumpPulse |=> !jumpPulse || $past(rdReq));
endmodule

bind seq_read_addr_gen seq_rd_checker #(
  .ADDR_W    (ADDR_W),
  .ALIGN_BITS(ALIGN_BITS)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .seedLoad (seedLoad),
  .seedAddr (seedAddr),
  .rdReq    (rdReq),
  .memAddr  (memAddr),
  .jumpPulse(jumpPulse)
);

// File: tb/test_seq_read_addr_gen.sv
module test_seq_read_addr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [31:0] seedAddr = '0;
  logic        rdReq = 1'b0;
  logic [31:0] rdAddrIn = '0;
  logic [31:0] memAddr;
  logic        jumpPulse;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic [31:0] mAddr = '0;
  logic [31:0] mMix  = '0;
  logic        mJump = 1'b0;

  always #4 clk = ~clk;

  seq_read_addr_gen i_seq_read_addr_gen (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedAddr(seedAddr),
    .rdReq(rdReq), .rdAddrIn(rdAddrIn), .memAddr(memAddr), .jumpPulse(jumpPulse)
  );

  task automatic check(input string req, input logic [31:0] expA, input logic expJ);
    nCmp++;
    if (memAddr !== expA || jumpPulse !== expJ) begin
      nBad++;
      $display("FAIL %s: memAddr=%h jumpPulse=%b, expected memAddr=%h jumpPulse=%b",
               req, memAddr, jumpPulse, expA, expJ);
    end
  endtask

  // One clock of stimulus, then model update and compare after the edge
  task automatic step(input string req, input logic sl, input logic [31:0] sa,
                      input logic rq, input logic [31:0] ra);
    logic [31:0] mx;
    @(negedge clk);
    seedLoad = sl; seedAddr = sa; rdReq = rq; rdAddrIn = ra;
    @(posedge clk);
    #1;
    if (sl) begin
      mAddr = {sa[31:3], 3'b000}; mMix = '0; mJump = 1'b0;
    end else if (rq) begin
      mx = mMix ^ ra;
      mMix = mx;
      if (mx[12:0] == 13'd0) begin mAddr = {mx[31:3], 3'b000}; mJump = 1'b1; end
      else begin mAddr = mAddr + 32'd8; mJump = 1'b0; end
    end else mJump = 1'b0;
    check(req, mAddr, mJump);
    if (memAddr[2:0] !== 3'b000) begin
      nCmp++; nBad++;
      $display("FAIL R4: memAddr=%h, expected low bits 000", memAddr);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1; nCmp++; nBad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 during reset", 32'h0, 1'b0);
    @(negedge clk) rstN = 1'b1;
    step("R1 first cycle", 1'b0, '0, 1'b0, '0);

    // R2: seed alignment, and mixing cleared so next read of 0x2000 jumps
    step("R2 seed", 1'b1, 32'h1234_5677, 1'b0, '0);
    step("R2 mix cleared", 1'b0, '0, 1'b1, 32'h0000_2000);
    step("R8 pulse ends", 1'b0, '0, 1'b0, '0);
    step("R9 idle hold", 1'b0, '0, 1'b0, 32'hFFFF_FFFF);

    // R3: collision; if 0x4001 were mixed, reading 0x4000 would not jump
    step("R3 collision", 1'b1, 32'h0000_1000, 1'b1, 32'h0000_4001);
    step("R3 read after", 1'b0, '0, 1'b1, 32'h0000_4000);

    // R6: wrap
    step("R6 seed top", 1'b1, 32'hFFFF_FFF8, 1'b0, '0);
    step("R6 wrap", 1'b0, '0, 1'b1, 32'h0000_0001);
    step("R5 after wrap", 1'b0, '0, 1'b1, 32'h0000_0002);

    // R7: trigger boundary sweep, exact zero vs one bit off
    for (int k = 0; k < 512; k++) begin
      step("R2 sweep seed", 1'b1, 32'h0800_0000 + (k << 4), 1'b0, '0);
      step("R7 near miss", 1'b0, '0, 1'b1,
           (32'(k) << 13) | (32'd1 << (k % 13)));
      step("R2 sweep seed", 1'b1, 32'h0800_0000 + (k << 4), 1'b0, '0);
      step("R7 exact hit", 1'b0, '0, 1'b1, (32'(k) << 13) ^ 32'h0000_0000);
      step("R8 one cycle", 1'b0, '0, 1'b0, '0);
    end

    // R5/R7/R8: long accumulating run with mixed idle cycles
    step("R2 run seed", 1'b1, 32'h00AB_CDE0, 1'b0, '0);
    for (int i = 1; i < 12000; i++) begin
      step("R5 R7 run", 1'b0, '0, (i % 7) != 0, 32'(i) * 32'h0000_9E37);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule